// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit up-counter and a watchdog counter that share one 8-bit prescaler. A small mode register picks where the counter's events come from: the instruction-cycle enable, or edges on an external pin that has already been synchronized. The same register picks the active edge of that pin, a 3-bit division code, and which of the two counters the prescaler serves. Whichever counter does not own the prescaler counts its own events without division.

The counter can be loaded through the write port. A load also empties the prescaler and holds off counting for two instruction cycles. When the counter rolls over from its top value to zero, it raises a one-cycle overflow pulse, which is meant to set the timer interrupt flag. The watchdog counts tick pulses from an external slow oscillator and raises a one-cycle timeout pulse when it wraps. A clear input restarts the watchdog. If the prescaler is serving the watchdog at that moment, the clear also empties the prescaler.

Top module: `tmr_presc_unit`

## Requirements
- R1: After reset the counter reads 0, `ovf_pulse` and `wdt_timeout` are low, and the mode register is 0: internal source, rising edge, prescaler on the counter, code 0.
- R2: Mode bits [2:0] hold the code k, bit [3] assigns the prescaler (0 counter, 1 watchdog), bit [4] selects the pin edge (0 rising, 1 falling), and bit [5] selects the source (0 instruction-cycle enable, 1 pin). With bit [3]=0 the counter advances once per 2^(k+1) source events.
- R3: With bit [3]=1 the counter advances by one on every source event.
- R4: With bit [5]=1 the counter takes its events from `ext_pin` edges of the polarity set by bit [4]. In this mode, pulses on `cyc_en` add no count.
- R5: A step from FFh wraps the counter to 00h. `ovf_pulse` is high for exactly the one cycle in which the counter first reads 00h.
- R6: `cnt_we` loads `wr_data` into the counter on the next edge and empties the prescaler. The next two `cyc_en` pulses after the load produce no count, whichever source is selected.
- R7: With bit [3]=1, each 2^k `wdt_tick` pulses advance the watchdog once. After 2^WDT_W advances, `wdt_timeout` pulses high for one cycle.
- R8: With bit [3]=0, every `wdt_tick` advances the watchdog.
- R9: `wdt_clr` empties the watchdog counter, and also empties the prescaler when bit [3]=1. A clear wins over a tick in the same cycle, and no timeout follows a clear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One-cycle pulse per instruction cycle |
| ext_pin | input | 1 | Synchronized external count input |
| wdt_tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| wdt_clr | input | 1 | Watchdog clear |
| cnt_we | input | 1 | Load the counter from `wr_data` |
| mode_we | input | 1 | Load the mode register from `wr_data[5:0]` |
| wr_data | input | CNT_W | Write data |
| cnt_q | output | CNT_W | Counter value |
| ovf_pulse | output | 1 | One-cycle rollover pulse |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The bench keeps the counter and prescaler at their default widths of 8, so all eight division codes can be reached, including the divide-by-256 case. It shrinks the watchdog to WDT_W=4, so a full timeout takes only 16 advances. That makes it cheap to count exactly how many ticks give a timeout under ratios of 1 and 4. It also makes it cheap to show that a clear mid-count, or a clear in the same cycle as a tick, restarts the sequence. The halved watchdog ratio against the counter ratio for the same code shows up when these tick counts are set next to the counter vectors.

// File: rtl/tmr_presc_unit.sv
module tmr_presc_unit #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             cnt_we,
  input  logic             mode_we,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_pulse,
  output logic             wdt_timeout
);
  localparam int RS_W   = $clog2(PS_W);
  localparam int MODE_W = RS_W + 3;
  localparam int B_ASG  = RS_W;
  localparam int B_EDGE = RS_W + 1;
  localparam int B_SRC  = RS_W + 2;

  logic [MODE_W-1:0] mode_r;
  logic [PS_W-1:0]   ps_r;
  logic [WDT_W-1:0]  wdt_r;
  logic [1:0]        inh_r;
  logic              pin_d;

  wire [RS_W-1:0] code    = mode_r[RS_W-1:0];
  wire            asg_wdt = mode_r[B_ASG];
  wire            fall    = mode_r[B_EDGE];
  wire            use_pin = mode_r[B_SRC];

  wire [PS_W:0] m_full = ({{PS_W{1'b0}}, 1'b1} << ({1'b0, code} + 1'b1)) - {{PS_W{1'b0}}, 1'b1};
  wire [PS_W-1:0] m_cnt = m_full[PS_W-1:0];
  wire [PS_W-1:0] m_wdt = m_full[PS_W:1];

  wire pin_evt = fall ? (pin_d & ~ext_pin) : (~pin_d & ext_pin);
  wire cnt_evt = (inh_r == 2'd0) && (use_pin ? pin_evt : cyc_en);
  wire ps_hit  = asg_wdt ? ((ps_r & m_wdt) == m_wdt) : ((ps_r & m_cnt) == m_cnt);
  wire ps_evt  = asg_wdt ? wdt_tick : cnt_evt;
  wire cnt_inc = cnt_evt && (asg_wdt || ps_hit);
  wire wdt_adv = wdt_tick && (!asg_wdt || ps_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      pin_d  <= 1'b0;
    end else begin
      pin_d <= ext_pin;
      if (mode_we) mode_r <= wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      inh_r <= 2'd0;
    else if (cnt_we)
      inh_r <= 2'd2;
    else if (cyc_en && inh_r != 2'd0)
      inh_r <= inh_r - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ps_r <= '0;
    else if (cnt_we || (wdt_clr && asg_wdt))
      ps_r <= '0;
    else if (ps_evt)
      ps_r <= ps_r + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else if (cnt_we) begin
      cnt_q     <= wr_data;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= cnt_inc && (&cnt_q);
      if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wdt_clr) begin
      wdt_r       <= '0;
      wdt_timeout <= 1'b0;
    end else begin
      wdt_timeout <= wdt_adv && (&wdt_r);
      if (wdt_adv) wdt_r <= wdt_r + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_presc_unit_chk.sv
module tmr_presc_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_we,
  input logic             wdt_clr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_pulse,
  input logic             wdt_timeout
);
  a_r5_ovf_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt_q == '0);

  a_r5_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wr_data));

  a_r6_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_we) && !cnt_we) |=> cnt_q == $past(cnt_q));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_we) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1);

  a_r9_no_timeout_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout);
endmodule

bind tmr_presc_unit tmr_presc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .wdt_clr(wdt_clr),
  .wr_data(wr_data), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse),
  .wdt_timeout(wdt_timeout)
);

// File: tb/tmr_presc_unit_bench.sv
module tmr_presc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {mode[39:32], start[31:24], cycles[23:8], expected[7:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 16'd12,  8'h05},
    {8'h02, 8'h10, 16'd34,  8'h14},
    {8'h08, 8'h20, 16'd9,   8'h27},
    {8'h01, 8'hFE, 16'd12,  8'h00},
    {8'h07, 8'h05, 16'd260, 8'h06},
    {8'h03, 8'h00, 16'd2,   8'h00},
    {8'h08, 8'h40, 16'd2,   8'h40},
    {8'h08, 8'h40, 16'd3,   8'h41},
    {8'h04, 8'h00, 16'd66,  8'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, wdt_clr = 1'b0;
  logic cnt_we = 1'b0, mode_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_q;
  logic ovf_pulse, wdt_timeout;
  int checks = 0, errors = 0, ovf_seen = 0, to_seen = 0, base;
  bit done = 1'b0;

  tmr_presc_unit #(.CNT_W(8), .PS_W(8), .WDT_W(4)) u_tmr_presc_unit (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .cnt_we(cnt_we), .mode_we(mode_we),
    .wr_data(wr_data), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse),
    .wdt_timeout(wdt_timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (ovf_pulse) ovf_seen++;
    if (wdt_timeout) to_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; wr_data = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_we = 1'b1; wr_data = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic icyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_en = 1'b1;
      @(negedge clk); cyc_en = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_tick = 1'b1;
      @(negedge clk); wdt_tick = 1'b0;
    end
  endtask

  task automatic clr();
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      @(negedge clk); ext_pin = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counter after reset", cnt_q, 0);
    chk("R1 ovf after reset", ovf_pulse, 0);
    chk("R1 timeout after reset", wdt_timeout, 0);
    icyc(6);
    chk("R1 default mode divides by 2", cnt_q, 3);

    for (int v = 0; v < NVEC; v++) begin
      wr_mode(VEC[v][39:32]);
      wr_cnt(VEC[v][31:24]);
      icyc(int'(VEC[v][23:8]));
      chk($sformatf("R2 R3 R6 vector %0d", v), cnt_q, int'(VEC[v][7:0]));
    end

    // R5 rollover pulse
    wr_mode(8'h08);
    wr_cnt(8'hFF);
    icyc(2);
    settle();
    base = ovf_seen;
    cyc_en = 1'b1;
    @(negedge clk); cyc_en = 1'b0;
    chk("R5 wrapped value", cnt_q, 0);
    chk("R5 ovf high", ovf_pulse, 1);
    @(negedge clk);
    chk("R5 ovf one cycle", ovf_pulse, 0);
    settle();
    chk("R5 ovf pulse count", ovf_seen - base, 1);

    // R6 load empties the prescaler
    wr_mode(8'h01);
    wr_cnt(8'h00);
    icyc(5);
    chk("R6 partial prescale", cnt_q, 0);
    wr_cnt(8'h10);
    icyc(5);
    chk("R6 prescaler emptied by load", cnt_q, 8'h10);
    icyc(1);
    chk("R6 count resumes", cnt_q, 8'h11);

    // R4 external pin, rising
    wr_mode(8'h28);
    wr_cnt(8'h00);
    icyc(2);
    pin_pulses(3);
    chk("R4 rising edges", cnt_q, 3);
    icyc(3);
    chk("R4 cyc_en ignored with pin source", cnt_q, 3);
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 rising counts at rise", cnt_q, 4);
    @(negedge clk); ext_pin = 1'b0;
    @(negedge clk); @(negedge clk);

    // R4 external pin, falling
    wr_mode(8'h38);
    wr_cnt(8'h00);
    icyc(2);
    pin_pulses(3);
    chk("R4 falling edges", cnt_q, 3);
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 falling ignores rise", cnt_q, 3);
    @(negedge clk); ext_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4 falling counts at fall", cnt_q, 4);

    // R7 watchdog, ratio 1
    wr_mode(8'h08);
    clr();
    ticks(15); settle(); base = to_seen;
    chk("R7 no timeout at 15 ticks", to_seen - base, 0);
    ticks(1); settle();
    chk("R7 timeout at 16 ticks", to_seen - base, 1);

    // R7 watchdog, code 2 -> ratio 4
    wr_mode(8'h0A);
    clr();
    settle(); base = to_seen;
    ticks(63); settle();
    chk("R7 no timeout at 63 ticks ratio 4", to_seen - base, 0);
    ticks(1); settle();
    chk("R7 timeout at 64 ticks ratio 4", to_seen - base, 1);

    // R8 prescaler on counter: watchdog undivided
    wr_mode(8'h03);
    clr();
    settle(); base = to_seen;
    ticks(15); settle();
    chk("R8 no timeout at 15 ticks", to_seen - base, 0);
    ticks(1); settle();
    chk("R8 timeout at 16 ticks", to_seen - base, 1);

    // R9 clear restarts watchdog
    wr_mode(8'h08);
    clr(); ticks(10); clr();
    settle(); base = to_seen;
    ticks(15); settle();
    chk("R9 clear restarts count", to_seen - base, 0);
    ticks(1); settle();
    chk("R9 timeout after restart", to_seen - base, 1);

    // R9 clear empties prescaler when assigned to watchdog
    wr_mode(8'h0A);
    clr(); ticks(3); clr();
    settle(); base = to_seen;
    ticks(63); settle();
    chk("R9 prescaler emptied by clear", to_seen - base, 0);
    ticks(1); settle();
    chk("R9 timeout after prescaler clear", to_seen - base, 1);

    // R9 clear beats a simultaneous tick
    wr_mode(8'h08);
    clr(); ticks(15);
    @(negedge clk); wdt_clr = 1'b1; wdt_tick = 1'b1;
    @(negedge clk); wdt_clr = 1'b0; wdt_tick = 1'b0;
    settle(); base = to_seen;
    ticks(15); settle();
    chk("R9 clear wins over tick", to_seen - base, 0);
    ticks(1); settle();
    chk("R9 timeout after clear with tick", to_seen - base, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule